// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This block performs 32-bit two's-complement arithmetic that clamps instead of wrapping. A three-bit operation code picks one of five forms. The forms differ in which operand is the minuend and where the second operand comes from: a register value, a sign-extended 5-bit immediate, or a sign-extended 16-bit immediate. When the exact result does not fit in 32 bits, the output is pinned to the largest positive or the most negative value. The overflow is then also reported twice: once in a per-operation flag and once in a sticky flag that stays set until software clears it.

The unit sits in an execute stage. The surrounding pipeline presents the two register values, the immediate field and a valid strobe. One clock later it receives the clamped result, the carry, overflow, sign and zero flags, and a valid strobe. Operand fetch, writeback and instruction decode belong to the surrounding pipeline.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 yields sat(b_i + a_i), where a_i is the first register operand and b_i is the second.
- R2: Operation code 1 yields sat(b_i + sext(imm_i[4:0])); bits imm_i[15:5] have no effect on this form.
- R3: Operation code 2 yields sat(b_i - a_i).
- R4: Operation code 3 yields the reversed difference sat(a_i - b_i).
- R5: Operation code 4 yields sat(a_i - sext(imm_i[15:0])).
- R6: When the exact signed result exceeds 7FFFFFFFh, the result is 7FFFFFFFh. When it is below -80000000h, the result is 80000000h. ov_o is 1 exactly when either clamp applies.
- R7: For the two add forms, cy_o is the carry out of the unsigned 32-bit sum. For the three subtract forms, cy_o is the borrow, which is 1 when the minuend is below the subtrahend taken as unsigned values.
- R8: s_o equals bit 31 of the clamped result, and z_o is 1 exactly when the clamped result is zero.
- R9: sat_o is set by any accepted overflowing operation, and no operation ever clears it. sat_clr_i clears it at the next edge. A clear in the same cycle as an overflow wins, so sat_o reads 0.
- R10: An operation accepted with valid_i at a clock edge appears on result_o and the flags in the following cycle, together with valid_o=1. When valid_i is 0, valid_o drops to 0 and result_o, cy_o, ov_o, s_o and z_o hold their values.
- R11: Operation codes 5 to 7 are reserved. With valid_i=1 they behave like an idle cycle: valid_o is 0, and the result, all flags and sat_o are unchanged.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 to 4 used, 5 to 7 reserved) |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| sat_clr_i | input | 1 | Clear the sticky saturation flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Clamped result |
| cy_o | output | 1 | Carry (add) or borrow (subtract) |
| ov_o | output | 1 | Overflow occurred |
| s_o | output | 1 | Sign of result |
| z_o | output | 1 | Result is zero |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives every form into positive and negative overflow. It uses the extreme operands 7FFFFFFFh, 80000000h and 0, and a design that clamped toward the wrong rail or wrapped would show up as a wrong result_o. Reversed and immediate subtracts are checked with asymmetric operands, so swapped operands produce the negated value. The bench also checks that carry and borrow come from the unclamped operation, and that the upper immediate bits are ignored by the short-immediate form. For the sticky flag, it tests clear in the same cycle as an overflow, non-overflowing operations after saturation, and reserved codes, any of which would expose a flag that clears too readily or sets on invalid work.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IMM_S_W = 5;
  localparam int unsigned IMM_L_W = 16;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_R = 3'd0,
    OP_ADD_I = 3'd1,
    OP_SUB_R = 3'd2,
    OP_RSUB  = 3'd3,
    OP_SUB_I = 3'd4
  } op_e;
endpackage

// File: rtl/sat_alu_opsel.sv
module sat_alu_opsel
  import sat_alu_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned IS_W = IMM_S_W,
  parameter int unsigned IL_W = IMM_L_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [IL_W-1:0] imm_i,
  output logic [W-1:0]    x_o,
  output logic [W-1:0]    y_o,
  output logic            sub_o,
  output logic            legal_o
);
  logic [W-1:0] imm_s, imm_l;
  assign imm_s = {{(W-IS_W){imm_i[IS_W-1]}}, imm_i[IS_W-1:0]};
  assign imm_l = {{(W-IL_W){imm_i[IL_W-1]}}, imm_i};

  // x is the augend/minuend, y the addend/subtrahend
  always_comb begin
    x_o     = b_i;
    y_o     = a_i;
    sub_o   = 1'b0;
    legal_o = 1'b1;
    unique case (op_i)
      OP_ADD_R: ;
      OP_ADD_I: y_o = imm_s;
      OP_SUB_R: sub_o = 1'b1;
      OP_RSUB: begin
        x_o = a_i; y_o = b_i; sub_o = 1'b1;
      end
      OP_SUB_I: begin
        x_o = a_i; y_o = imm_l; sub_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sat_alu_core.sv
module sat_alu_core #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ov_o
);
  localparam logic [W-1:0] MAX_P = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_N = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] y_eff;
  logic [W:0]   sum;
  logic [W-1:0] raw;

  assign y_eff = sub_i ? ~y_i : y_i;
  assign sum   = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, sub_i};
  assign raw   = sum[W-1:0];
  // borrow is the inverted carry of x + ~y + 1
  assign cy_o  = sum[W] ^ sub_i;
  assign ov_o  = (x_i[W-1] == y_eff[W-1]) && (raw[W-1] != x_i[W-1]);
  // overflow direction follows the sign of x
  assign res_o = !ov_o ? raw : (x_i[W-1] ? MIN_N : MAX_P);
endmodule

// File: rtl/sat_alu_flags.sv
module sat_alu_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  input  logic [W-1:0] res_i,
  input  logic         cy_i,
  input  logic         ov_i,
  input  logic         clr_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         cy_o,
  output logic         ov_o,
  output logic         s_o,
  output logic         z_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAX_P = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_N = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      cy_o     <= 1'b0;
      ov_o     <= 1'b0;
      s_o      <= 1'b0;
      z_o      <= 1'b0;
    end else begin
      valid_o <= take_i;
      if (take_i) begin
        result_o <= res_i;
        cy_o     <= cy_i;
        ov_o     <= ov_i;
        s_o      <= res_i[W-1];
        z_o      <= (res_i == '0);
      end
    end
  end

  // clear has priority over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sat_o <= 1'b0;
    else if (clr_i)             sat_o <= 1'b0;
    else if (take_i && ov_i)    sat_o <= 1'b1;
  end

  a_r6_clamp_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ov_o) |-> (result_o == MAX_P || result_o == MIN_N));
  a_r8_sign_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (s_o == result_o[W-1] && z_o == (result_o == '0)));
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sat_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_i) |=> sat_o);
  a_r9_ov_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && ov_i && !clr_i) |=> (sat_o && ov_o));
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_L_W-1:0] imm_i,
  input  logic              sat_clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cy_o,
  output logic              ov_o,
  output logic              s_o,
  output logic              z_o,
  output logic              sat_o
);
  logic [DATA_W-1:0] x, y, res;
  logic sub, legal, cy, ov, take;

  sat_alu_opsel #(.W(DATA_W), .IS_W(IMM_S_W), .IL_W(IMM_L_W)) u_opsel (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .x_o(x), .y_o(y), .sub_o(sub), .legal_o(legal)
  );

  sat_alu_core #(.W(DATA_W)) u_core (
    .x_i(x), .y_i(y), .sub_i(sub), .res_o(res), .cy_o(cy), .ov_o(ov)
  );

  assign take = valid_i && legal;

  sat_alu_flags #(.W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .res_i(res),
    .cy_i(cy), .ov_i(ov), .clr_i(sat_clr_i),
    .valid_o(valid_o), .result_o(result_o), .cy_o(cy_o), .ov_o(ov_o),
    .s_o(s_o), .z_o(z_o), .sat_o(sat_o)
  );

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(cy_o) && $stable(ov_o)));
  a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4 && !sat_clr_i) |=> (!valid_o && $stable(result_o) && $stable(sat_o)));
endmodule

// File: tb/sat_alu_tb_top.sv
`timescale 1ns/1ps
module sat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic        clr_i = 1'b0;
  logic        valid_o, cy_o, ov_o, s_o, z_o, sat_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [31:0] e_res = '0;
  logic e_valid = 0, e_cy = 0, e_ov = 0, e_s = 0, e_z = 0, e_sat = 0;

  always #4 clk = ~clk;

  sat_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .sat_clr_i(clr_i),
    .valid_o(valid_o), .result_o(result_o), .cy_o(cy_o), .ov_o(ov_o),
    .s_o(s_o), .z_o(z_o), .sat_o(sat_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "valid_o", {31'b0, valid_o}, {31'b0, e_valid});
    chk(tag, "result_o", result_o, e_res);
    chk(tag, "cy_o", {31'b0, cy_o}, {31'b0, e_cy});
    chk(tag, "ov_o", {31'b0, ov_o}, {31'b0, e_ov});
    chk(tag, "s_o", {31'b0, s_o}, {31'b0, e_s});
    chk(tag, "z_o", {31'b0, z_o}, {31'b0, e_z});
    chk(tag, "sat_o", {31'b0, sat_o}, {31'b0, e_sat});
  endtask

  // behavioural reference for one clock
  task automatic model(logic v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic clr);
    longint x, y, r;
    longint unsigned ux, uy;
    logic is_sub, ov;
    logic [63:0] u;
    if (v && op <= 3'd4) begin
      case (op)
        3'd0: begin x = longint'($signed(b)); y = longint'($signed(a)); is_sub = 0; end
        3'd1: begin x = longint'($signed(b)); y = longint'($signed(imm[4:0])); is_sub = 0; end
        3'd2: begin x = longint'($signed(b)); y = longint'($signed(a)); is_sub = 1; end
        3'd3: begin x = longint'($signed(a)); y = longint'($signed(b)); is_sub = 1; end
        default: begin x = longint'($signed(a)); y = longint'($signed(imm)); is_sub = 1; end
      endcase
      ux = longint'(x) & 64'hFFFF_FFFF;
      uy = longint'(y) & 64'hFFFF_FFFF;
      if (is_sub) begin r = x - y; e_cy = (ux < uy); end
      else begin r = x + y; u = ux + uy; e_cy = u[32]; end
      ov = 1'b1;
      if (r > 64'sd2147483647) e_res = 32'h7FFF_FFFF;
      else if (r < -64'sd2147483648) e_res = 32'h8000_0000;
      else begin e_res = r[31:0]; ov = 1'b0; end
      e_ov = ov;
      e_s = e_res[31];
      e_z = (e_res == 0);
      e_valid = 1'b1;
      if (ov) e_sat = 1'b1;
    end else begin
      e_valid = 1'b0;
    end
    if (clr) e_sat = 1'b0;
  endtask

  task automatic step(string tag, logic v, logic [2:0] op, logic [31:0] a,
                      logic [31:0] b, logic [15:0] imm, logic clr);
    valid_i = v; op_i = op; a_i = a; b_i = b; imm_i = imm; clr_i = clr;
    @(negedge clk);
    model(v, op, a, b, imm, clr);
    compare(tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12");

    // R1 register add
    step("R1", 1, 3'd0, 32'd5, 32'd7, 16'h0, 0);
    step("R1", 1, 3'd0, 32'd1, 32'h7FFF_FFFF, 16'h0, 0);        // +ovf
    step("R1", 1, 3'd0, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 0); // -ovf
    step("R1", 1, 3'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1);         // zero, carry
    // R2 short immediate add, upper bits ignored
    step("R2", 1, 3'd1, 32'h0, 32'd10, 16'hFFE3, 0);  // imm5=-29? 5'h03 -> +3
    step("R2", 1, 3'd1, 32'h0, 32'd10, 16'h0010, 0);  // -16
    step("R2", 1, 3'd1, 32'h0, 32'h7FFF_FFFE, 16'h000F, 0);
    step("R2", 1, 3'd1, 32'h0, 32'h8000_0005, 16'hFFF0, 1);
    step("R2", 1, 3'd1, 32'h0, 32'h8000_0005, 16'h0010, 0);
    // R3 subtract b - a
    step("R3", 1, 3'd2, 32'd3, 32'd10, 16'h0, 1);
    step("R3", 1, 3'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 0);
    step("R3", 1, 3'd2, 32'd1, 32'h8000_0000, 16'h0, 1);
    // R4 reverse subtract a - b
    step("R4", 1, 3'd3, 32'd3, 32'd10, 16'h0, 0);
    step("R4", 1, 3'd3, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1);
    step("R4", 1, 3'd3, 32'h8000_0000, 32'd1, 16'h0, 0);
    // R5 long immediate subtract
    step("R5", 1, 3'd4, 32'd100, 32'hDEAD, 16'h0064, 1);
    step("R5", 1, 3'd4, 32'h7FFF_FFF0, 32'h0, 16'h8000, 0);
    step("R5", 1, 3'd4, 32'h8000_0010, 32'h0, 16'h7FFF, 0);
    // R9 non-overflowing ops keep sat, clear wins over same-cycle set
    step("R9", 1, 3'd0, 32'd1, 32'd1, 16'h0, 0);
    step("R9", 1, 3'd0, 32'd1, 32'h7FFF_FFFF, 16'h0, 1);
    step("R9", 0, 3'd0, 32'd0, 32'd0, 16'h0, 0);
    // R10 idle holds
    step("R10", 1, 3'd2, 32'd1, 32'd9, 16'h0, 0);
    step("R10", 0, 3'd2, 32'd4, 32'd4, 16'h0, 0);
    // R11 reserved codes
    step("R6", 1, 3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0);
    step("R11", 1, 3'd5, 32'h7FFF_FFFF, 32'd1, 16'h0, 0);
    step("R11", 1, 3'd7, 32'd0, 32'd0, 16'h0, 0);
    step("R8", 1, 3'd2, 32'd5, 32'd5, 16'h0, 1);
    step("R11", 1, 3'd6, 32'h7FFF_FFFF, 32'd1, 16'h0, 0);
    // R7 carry/borrow with random operands across all forms
    for (int i = 0; i < 600; i++) begin
      step("R7", ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
           pick(), pick(), 16'($urandom), ($urandom_range(0, 9) == 0));
    end
    summary();
    $finish;
  end
endmodule